// File: doc/BRIEF.md
# Multi-Lane SPI Word Engine

This block is the data path of an SPI controller that drives several independent data lanes from a single chip select and a single serial clock. Each lane has its own shift register and carries whole words. This differs from dual or quad wiring, where the bits of one word are spread across several wires. On every clock the lanes move words side by side, so a simultaneous-sampling converter with one output pin per channel can be read in the time needed for one word.

A transfer is launched with a mode, a direction and a total word count. In single-lane mode only the primary lane (lane 0) is used. In stripe mode each lane carries a different word, and the word stream is interleaved by lane index. In mirror mode one word is copied to every enabled transmit lane. Lane enables come from two mask registers written through a small command port, and a read-only word reports the lane count and the word width. Transmit words enter on a valid/ready stream, and received words leave on a second valid/ready stream.

Top module: `mlane_spi_core`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, every sdo bit is 0, and done, err, rx_valid and tx_ready are 0. Both lane masks hold 1, which enables lane 0 only.
- R2: info_word carries the lane count in bits 23:16, the word width in bits 15:0, and zero in bits 31:24.
- R3: Mode 0 (single) transmit sends xfer_len words on lane 0, one word per burst of WORD_W clocks, MSB first. All other sdo bits stay 0 whatever the masks hold.
- R4: Mode 0 receive shifts in xfer_len words from sdi[0], MSB first, and presents them in arrival order on the receive stream. Stalls of rx_ready lose no word.
- R5: Mode 2 (mirror) transmit sends each input word at the same time on every lane whose transmit mask bit is 1.
- R6: Mode 1 (stripe) transmit takes input word k to lane k mod LANES, in burst k div LANES. A transfer lasts xfer_len/LANES bursts.
- R7: Mode 1 receive emits, for each burst, the word of lane 0 first, then lane 1 and so on up to the last lane. For example, lane 0 shifting in 0x11 and lane 1 shifting in 0x88 give output words 0x11 then 0x88.
- R8: A lane whose mask bit is 0 keeps sdo at 0 and ignores sdi. In stripe receive it yields the word 0 in its slot.
- R9: A command write to address 3 loads the receive mask from cmd_wdata, and a write to address 4 loads the transmit mask. Writes to any other address change nothing.
- R10: A request is rejected if it is mirror receive, mode 3, has a zero word count, or is a stripe count that is not a multiple of LANES. A rejected request gives a one-cycle err pulse, cs_n stays 1 and no clock runs.
- R11: When a stripe transfer completes, both masks return to 1 (lane 0 only).
- R12: Each accepted transfer gives exactly one done pulse, one cycle after the final sclk-high cycle of the last burst. For receive, the words of that last burst follow done on the stream.
- R13: sclk is 0 whenever cs_n is 1. sdo changes only while sclk is low. sdi is sampled as sclk rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_addr | input | 3 | Command register address (3 = receive mask, 4 = transmit mask) |
| cmd_wdata | input | 8 | Command write data; the low LANES bits are used |
| info_word | output | 32 | Lane count in bits 23:16, word width in bits 15:0 |
| start | input | 1 | Request a transfer; accepted while cs_n is 1 |
| mode | input | 2 | 0 single, 1 stripe, 2 mirror |
| op_rx | input | 1 | 1 receive, 0 transmit |
| xfer_len | input | LEN_W | Total word count of the transfer |
| done | output | 1 | One-cycle pulse after the final bit |
| err | output | 1 | One-cycle pulse on a rejected request |
| tx_data | input | WORD_W | Transmit word stream data |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Engine takes a transmit word |
| rx_data | output | WORD_W | Received word stream data |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| cs_n | output | 1 | Shared chip select, active low |
| sclk | output | 1 | Shared serial clock, idle low |
| sdo | output | LANES | Per-lane serial data out |
| sdi | input | LANES | Per-lane serial data in |

## Verification
The bench sweeps every transmit mask in mirror mode and every receive mask in stripe mode on a four-lane, eight-bit build. It also rebuilds each lane's bit stream from the pins and compares it with words it computes itself. A lane-select or interleave error would put words on the wrong lane or in the wrong stream order. A mask that leaks would show data on a disabled lane. A design that forgets to fall back after a stripe transfer would keep extra lanes live in the next transfer, which the bench runs without rewriting the masks. The bench also drives each illegal request, where a faulty engine would run the clock or lower cs_n. It times done against the last clock rise and against the received words already delivered, which catches an early done or one that arrives after the stream is drained.

// File: rtl/mlane_pkg.sv
package mlane_pkg;

  // Transfer mode codes
  localparam logic [1:0] XM_SINGLE = 2'd0;
  localparam logic [1:0] XM_STRIPE = 2'd1;
  localparam logic [1:0] XM_MIRROR = 2'd2;

  // Command register addresses
  localparam logic [2:0] CMD_RX_MASK = 3'd3;
  localparam logic [2:0] CMD_TX_MASK = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_DRAIN
  } seq_state_e;

  // A request is legal when it has words, is not a mirrored read, uses a
  // defined mode and, for stripe, fills every lane the same number of times.
  function automatic logic req_legal(input logic [1:0] m, input logic rx,
                                     input int unsigned len, input int unsigned lanes);
    if (len == 0) return 1'b0;
    if (m == 2'd3) return 1'b0;
    if (m == XM_MIRROR && rx) return 1'b0;
    if (m == XM_STRIPE && (len % lanes) != 0) return 1'b0;
    return 1'b1;
  endfunction

  // Number of WORD_W-clock bursts a legal request needs
  function automatic int unsigned burst_count(input logic [1:0] m, input int unsigned len,
                                              input int unsigned lanes);
    return (m == XM_STRIPE) ? len / lanes : len;
  endfunction

  function automatic logic [31:0] info_pack(input int unsigned lanes, input int unsigned width);
    logic [31:0] v;
    v = '0;
    v[23:16] = lanes[7:0];
    v[15:0]  = width[15:0];
    return v;
  endfunction

endpackage

// File: rtl/mlane_cfg.sv
module mlane_cfg
  import mlane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             revert,
  output logic [LANES-1:0] rx_mask,
  output logic [LANES-1:0] tx_mask,
  output logic [31:0]      info
);

  localparam logic [LANES-1:0] PRIMARY = LANES'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mask <= PRIMARY;
      tx_mask <= PRIMARY;
    end else if (revert) begin
      rx_mask <= PRIMARY;
      tx_mask <= PRIMARY;
    end else if (we) begin
      if (addr == CMD_RX_MASK) rx_mask <= wdata[LANES-1:0];
      if (addr == CMD_TX_MASK) tx_mask <= wdata[LANES-1:0];
    end
  end

  assign info = info_pack(LANES, WORD_W);

endmodule

// File: rtl/mlane_shifter.sv
module mlane_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              capture,
  input  logic              shift,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] shreg;
  logic              cap_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cap_bit <= 1'b0;
    end else begin
      if (load)       shreg <= load_word;
      else if (shift) shreg <= {shreg[WORD_W-2:0], cap_bit};
      if (capture)    cap_bit <= rx_en & sdi;
    end
  end

  assign sdo  = tx_en & shreg[WORD_W-1];
  assign word = shreg;

endmodule

// File: rtl/mlane_ctrl.sv
module mlane_ctrl
  import mlane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 8,
  parameter int LEN_W  = 8,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             op_rx,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [LANES-1:0] rx_mask,
  input  logic [LANES-1:0] tx_mask,
  input  logic             tx_valid,
  input  logic             rx_ready,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic             cs_n,
  output logic             sclk,
  output logic             capture,
  output logic             shift,
  output logic             load,
  output logic             stripe,
  output logic [IDX_W-1:0] lane_idx,
  output logic [LANES-1:0] lane_tx_en,
  output logic [LANES-1:0] lane_rx_en,
  output logic             done,
  output logic             err,
  output logic             revert
);

  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(LANES - 1);

  seq_state_e       state;
  logic [1:0]       cur_mode;
  logic             cur_rx;
  logic [LEN_W-1:0] bursts_left;
  logic [IDX_W-1:0] idx;
  logic [BIT_W-1:0] bitcnt;
  logic             ph;

  logic             at_last_lane;
  logic             bit_end;
  logic             last_burst;
  logic             seq_end;
  logic             ok;

  assign stripe       = (cur_mode == XM_STRIPE);
  assign at_last_lane = stripe ? (idx == LAST_LANE) : (idx == '0);
  assign bit_end      = (state == ST_SHIFT) && ph && (bitcnt == LAST_BIT);
  assign last_burst   = (bursts_left == LEN_W'(1));
  assign seq_end      = (bit_end && last_burst && !cur_rx) ||
                        ((state == ST_DRAIN) && rx_ready && at_last_lane && (bursts_left == '0));
  assign revert       = seq_end && stripe;
  assign ok           = req_legal(mode, op_rx, 32'(xfer_len), LANES);

  assign cs_n     = (state == ST_IDLE);
  assign sclk     = (state == ST_SHIFT) && ph;
  assign capture  = (state == ST_SHIFT) && !ph;
  assign shift    = (state == ST_SHIFT) && ph;
  assign tx_ready = (state == ST_LOAD);
  assign rx_valid = (state == ST_DRAIN);
  assign load     = (state == ST_LOAD) && tx_valid;
  assign lane_idx = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_mode    <= XM_SINGLE;
      cur_rx      <= 1'b0;
      bursts_left <= '0;
      idx         <= '0;
      bitcnt      <= '0;
      ph          <= 1'b0;
      lane_tx_en  <= '0;
      lane_rx_en  <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (ok) begin
              cur_mode    <= mode;
              cur_rx      <= op_rx;
              bursts_left <= LEN_W'(burst_count(mode, 32'(xfer_len), LANES));
              idx         <= '0;
              bitcnt      <= '0;
              ph          <= 1'b0;
              if (mode == XM_SINGLE) begin
                lane_tx_en <= op_rx ? '0 : LANES'(1);
                lane_rx_en <= op_rx ? LANES'(1) : '0;
              end else begin
                lane_tx_en <= op_rx ? '0 : tx_mask;
                lane_rx_en <= op_rx ? rx_mask : '0;
              end
              state <= op_rx ? ST_SHIFT : ST_LOAD;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (tx_valid) begin
            if (at_last_lane) begin
              idx   <= '0;
              state <= ST_SHIFT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          ph <= ~ph;
          if (ph) begin
            if (bitcnt == LAST_BIT) begin
              bitcnt      <= '0;
              bursts_left <= bursts_left - 1'b1;
              if (cur_rx) begin
                state <= ST_DRAIN;
                done  <= last_burst;
              end else if (last_burst) begin
                state      <= ST_IDLE;
                done       <= 1'b1;
                lane_tx_en <= '0;
              end else begin
                state <= ST_LOAD;
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (rx_ready) begin
            if (at_last_lane) begin
              idx <= '0;
              if (bursts_left == '0) begin
                state      <= ST_IDLE;
                lane_rx_en <= '0;
              end else begin
                state <= ST_SHIFT;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mlane_spi_core.sv
module mlane_spi_core
  import mlane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [2:0]        cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic [31:0]       info_word,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              op_rx,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              done,
  output logic              err,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              cs_n,
  output logic              sclk,
  output logic [LANES-1:0]  sdo,
  input  logic [LANES-1:0]  sdi
);

  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0]  rx_mask;
  logic [LANES-1:0]  tx_mask;
  logic [LANES-1:0]  lane_tx_en;
  logic [LANES-1:0]  lane_rx_en;
  logic [LANES-1:0]  lane_load;
  logic              revert;
  logic              capture;
  logic              shift;
  logic              load;
  logic              stripe;
  logic [IDX_W-1:0]  lane_idx;
  logic [WORD_W-1:0] lane_word [LANES];

  mlane_cfg #(.LANES(LANES), .WORD_W(WORD_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cmd_we),
    .addr    (cmd_addr),
    .wdata   (cmd_wdata),
    .revert  (revert),
    .rx_mask (rx_mask),
    .tx_mask (tx_mask),
    .info    (info_word)
  );

  mlane_ctrl #(.LANES(LANES), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .op_rx      (op_rx),
    .xfer_len   (xfer_len),
    .rx_mask    (rx_mask),
    .tx_mask    (tx_mask),
    .tx_valid   (tx_valid),
    .rx_ready   (rx_ready),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .capture    (capture),
    .shift      (shift),
    .load       (load),
    .stripe     (stripe),
    .lane_idx   (lane_idx),
    .lane_tx_en (lane_tx_en),
    .lane_rx_en (lane_rx_en),
    .done       (done),
    .err        (err),
    .revert     (revert)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_load[l] = load && (!stripe || (lane_idx == IDX_W'(l)));

    mlane_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (lane_load[l]),
      .load_word (tx_data),
      .capture   (capture),
      .shift     (shift),
      .tx_en     (lane_tx_en[l]),
      .rx_en     (lane_rx_en[l]),
      .sdi       (sdi[l]),
      .sdo       (sdo[l]),
      .word      (lane_word[l])
    );
  end

  assign rx_data = stripe ? lane_word[lane_idx] : lane_word[0];

endmodule

// File: rtl/mlane_chk.sv
module mlane_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             done,
  input logic             err,
  input logic             rx_valid,
  input logic             tx_ready,
  input logic [LANES-1:0] sdo,
  input logic [LANES-1:0] lane_tx_en
);

  // R13
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R13
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));

  // R8
  sdo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo & ~lane_tx_en) == '0);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sclk));

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cs_n);

  // R7
  stream_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || tx_ready) |-> !cs_n);

endmodule

bind mlane_spi_core mlane_chk #(.LANES(LANES)) u_mlane_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .done       (done),
  .err        (err),
  .rx_valid   (rx_valid),
  .tx_ready   (tx_ready),
  .sdo        (sdo),
  .lane_tx_en (lane_tx_en)
);

// File: tb/test_mlane_spi_core.sv
module test_mlane_spi_core;

  localparam int N  = 4;
  localparam int W  = 8;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_we = 1'b0;
  logic [2:0]    cmd_addr = '0;
  logic [7:0]    cmd_wdata = '0;
  logic [31:0]   info_word;
  logic          start = 1'b0;
  logic [1:0]    mode = '0;
  logic          op_rx = 1'b0;
  logic [LW-1:0] xfer_len = '0;
  logic          done, err;
  logic [W-1:0]  tx_data = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [W-1:0]  rx_data;
  logic          rx_valid;
  logic          rx_ready = 1'b1;
  logic          cs_n, sclk;
  logic [N-1:0]  sdo;
  logic [N-1:0]  sdi;

  always #2 clk = ~clk;

  mlane_spi_core #(.LANES(N), .WORD_W(W), .LEN_W(LW)) i_mlane_spi_core (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .info_word(info_word), .start(start), .mode(mode), .op_rx(op_rx), .xfer_len(xfer_len),
    .done(done), .err(err), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .cs_n(cs_n), .sclk(sclk),
    .sdo(sdo), .sdi(sdi)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Peripheral model: per-lane receive words, changed after each sclk fall
  logic [7:0] rx_base [N];
  int fall_cnt = 0;
  logic prev_f = 1'b0;

  function automatic logic [7:0] rx_word(input int l, input int b);
    return 8'(rx_base[l] + 8'(b * 53));
  endfunction

  always @(negedge clk) begin
    logic [7:0] w;
    if (cs_n) fall_cnt = 0;
    else if (prev_f && !sclk) fall_cnt++;
    prev_f = sclk;
    for (int l = 0; l < N; l++) begin
      w = rx_word(l, fall_cnt / W);
      sdi[l] = w[W-1-(fall_cnt % W)];
    end
  end

  // Pin monitor: rebuild each lane's transmitted words at sclk rises
  logic [7:0] acc [N];
  logic [7:0] cap [N][16];
  int rise_cnt = 0;
  logic prev_r = 1'b0;
  logic prev_cs = 1'b1;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) rise_cnt = 0;
    if (!cs_n && !prev_r && sclk) begin
      for (int l = 0; l < N; l++) begin
        acc[l] = {acc[l][6:0], sdo[l]};
        if (rise_cnt % W == W - 1) cap[l][(rise_cnt / W) % 16] = acc[l];
      end
      rise_cnt++;
    end
    prev_r  = sclk;
    prev_cs = cs_n;
  end

  logic [7:0] txw [64];
  logic [7:0] rxgot [64];
  int dcnt, ecnt, rise_done, nrx_done, nrx, cs_low;

  task automatic cmd_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_we = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic set_tx_words(input int seed);
    for (int k = 0; k < 64; k++) txw[k] = 8'(k * 59 + seed);
  endtask

  task automatic run(input logic [1:0] m, input bit rx, input int len, input bit bp);
    int cyc;
    int k;
    for (int l = 0; l < N; l++)
      for (int b = 0; b < 16; b++) cap[l][b] = 8'h5A;
    dcnt = 0; ecnt = 0; rise_done = -1; nrx_done = -1; nrx = 0; cs_low = 0;
    k = 0; cyc = 0;
    @(negedge clk);
    mode = m; op_rx = rx; xfer_len = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (done) begin dcnt++; rise_done = rise_cnt; nrx_done = nrx; end
      if (err) ecnt++;
      if (!cs_n) cs_low = 1;
      rx_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      if (rx_valid && rx_ready) begin rxgot[nrx % 64] = rx_data; nrx++; end
      if (k < len) begin
        tx_valid = 1'b1; tx_data = txw[k];
        if (tx_ready) k++;
      end else begin
        tx_valid = 1'b0;
      end
      if (cs_n && cyc >= 6) break;
      if (cyc > 4000) begin
        errors++;
        $display("FAIL watchdog: transfer hung, actual %0d cycles expected < 4000", cyc);
        break;
      end
      cyc++;
      @(negedge clk);
    end
    tx_valid = 1'b0;
    rx_ready = 1'b1;
  endtask

  function automatic int bursts(input logic [1:0] m, input int len);
    return (m == 2'd1) ? len / N : len;
  endfunction

  task automatic check_tx(input string req, input logic [1:0] m, input int len, input logic [N-1:0] mask);
    int nb;
    int exp;
    nb = bursts(m, len);
    chk("R12", "done pulses", dcnt, 1);
    chk("R12", "rises at done", rise_done, nb * W);
    chk(req, "burst rises", rise_cnt, nb * W);
    for (int b = 0; b < nb; b++)
      for (int l = 0; l < N; l++) begin
        if (m == 2'd0)      exp = (l == 0) ? int'(txw[b]) : 0;
        else if (m == 2'd2) exp = mask[l] ? int'(txw[b]) : 0;
        else                exp = mask[l] ? int'(txw[b * N + l]) : 0;
        chk(req, $sformatf("lane %0d burst %0d", l, b), int'(cap[l][b]), exp);
      end
  endtask

  task automatic check_rx(input string req, input logic [1:0] m, input int len, input logic [N-1:0] mask);
    int nb;
    int wpb;
    int exp;
    int l;
    nb = bursts(m, len);
    wpb = (m == 2'd1) ? N : 1;
    chk("R12", "done pulses", dcnt, 1);
    chk("R12", "rises at done", rise_done, nb * W);
    chk("R12", "words before done", nrx_done, (nb - 1) * wpb);
    chk(req, "word count", nrx, len);
    for (int k = 0; k < len; k++) begin
      if (m == 2'd1) begin
        l = k % N;
        exp = mask[l] ? int'(rx_word(l, k / N)) : 0;
      end else begin
        exp = int'(rx_word(0, k));
      end
      chk(req, $sformatf("word %0d", k), int'(rxgot[k]), exp);
    end
  endtask

  task automatic check_reject(input logic [1:0] m, input bit rx, input int len);
    run(m, rx, len, 1'b0);
    chk("R10", $sformatf("err pulses m%0d rx%0d len%0d", m, rx, len), ecnt, 1);
    chk("R10", "cs_n never low", cs_low, 0);
    chk("R10", "no done", dcnt, 0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: global timeout, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < N; l++) rx_base[l] = 8'(8'h21 + l * 8'h46);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "cs_n", int'(cs_n), 1);
    chk("R1", "sclk", int'(sclk), 0);
    chk("R1", "sdo", int'(sdo), 0);
    chk("R1", "done/err", int'({done, err}), 0);
    chk("R1", "rx_valid/tx_ready", int'({rx_valid, tx_ready}), 0);
    // R2 info layout
    chk("R2", "lane field", int'(info_word[23:16]), N);
    chk("R2", "width field", int'(info_word[15:0]), W);
    chk("R2", "top byte", int'(info_word[31:24]), 0);

    // R1 default masks: mirror with no mask write uses lane 0 only
    set_tx_words(7);
    run(2'd2, 1'b0, 1, 1'b0);
    check_tx("R1", 2'd2, 1, 4'b0001);

    // R3 single transmit ignores a wide mask
    cmd_write(3'd4, 8'h0F);
    for (int len = 1; len <= 3; len++) begin
      set_tx_words(len * 17);
      run(2'd0, 1'b0, len, 1'b0);
      check_tx("R3", 2'd0, len, 4'b0001);
    end

    // R4 single receive, with and without back-pressure
    for (int len = 1; len <= 3; len++) begin
      run(2'd0, 1'b1, len, len == 3);
      check_rx("R4", 2'd0, len, 4'b0001);
    end

    // R5 R8 R9 mirror transmit over every transmit mask
    for (int mk = 0; mk < 16; mk++) begin
      cmd_write(3'd4, 8'(mk));
      set_tx_words(mk * 5 + 3);
      run(2'd2, 1'b0, 2, 1'b0);
      check_tx("R5", 2'd2, 2, 4'(mk));
    end

    // R9 writes to other addresses leave the transmit mask alone
    cmd_write(3'd4, 8'h0F);
    cmd_write(3'd5, 8'h00);
    cmd_write(3'd2, 8'h00);
    cmd_write(3'd0, 8'h01);
    set_tx_words(99);
    run(2'd2, 1'b0, 1, 1'b0);
    check_tx("R9", 2'd2, 1, 4'b1111);

    // R6 stripe transmit, then R11 fallback seen by the next mirror
    for (int len = 4; len <= 8; len += 4) begin
      cmd_write(3'd4, 8'h0F);
      set_tx_words(len * 11);
      run(2'd1, 1'b0, len, 1'b0);
      check_tx("R6", 2'd1, len, 4'b1111);
    end
    cmd_write(3'd4, 8'h0B);
    set_tx_words(41);
    run(2'd1, 1'b0, 8, 1'b0);
    check_tx("R8", 2'd1, 8, 4'b1011);
    set_tx_words(42);
    run(2'd2, 1'b0, 1, 1'b0);
    check_tx("R11", 2'd2, 1, 4'b0001);

    // R7 example words 0x11 and 0x88 on lanes 0 and 1
    rx_base[0] = 8'h11; rx_base[1] = 8'h88; rx_base[2] = 8'h3C; rx_base[3] = 8'hC3;
    cmd_write(3'd3, 8'h03);
    run(2'd1, 1'b1, 4, 1'b0);
    check_rx("R7", 2'd1, 4, 4'b0011);
    chk("R7", "first word", int'(rxgot[0]), 8'h11);
    chk("R7", "second word", int'(rxgot[1]), 8'h88);

    // R7 R8 stripe receive over every receive mask with back-pressure
    for (int mk = 0; mk < 16; mk++) begin
      for (int l = 0; l < N; l++) rx_base[l] = 8'(mk * 13 + l * 71 + 5);
      cmd_write(3'd3, 8'(mk));
      run(2'd1, 1'b1, 8, mk[0]);
      check_rx("R8", 2'd1, 8, 4'(mk));
    end

    // R11 receive mask fell back after the last stripe receive
    run(2'd1, 1'b1, 4, 1'b0);
    check_rx("R11", 2'd1, 4, 4'b0001);

    // R10 rejected requests
    check_reject(2'd2, 1'b1, 2);
    check_reject(2'd1, 1'b0, 6);
    check_reject(2'd1, 1'b1, 3);
    check_reject(2'd0, 1'b0, 0);
    check_reject(2'd3, 1'b0, 4);

    // R10 a rejected request leaves the engine usable
    set_tx_words(77);
    run(2'd0, 1'b0, 1, 1'b0);
    check_tx("R10", 2'd0, 1, 4'b0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule